// File: doc/BRIEF.md
# Character-Cell Screen Address Generator

This block produces the byte address sequence for a bitmap display whose memory is arranged in character cells. A character row is eight pixel lines tall and is stored as a run of 8-byte columns. Each column holds one byte for each of the row's eight lines. As a result, the address steps by 8 along a pixel line, moves to the next byte of the same column at the end of a line, and falls back by 7 when a character row is finished. The screen region always ends just below address 0x8000. Any address that reaches 0x8000 folds back into the region.

A geometry selection picks 32 or 25 character rows and 80 or 40 bytes per pixel line. From that selection the block derives the screen start, the fold span, the number of blank spacing lines between rows, and the length of the footer margin. The selection is sampled only on a frame-start strobe. A timing generator drives single-cycle strobes for byte fetches, line ends and frame start, together with a level that marks the active region. These are plain control pins with no handshake. The block always accepts a strobe in the cycle it arrives and never applies back-pressure. The address output feeds a memory fetch path. The blank output tells the pixel path to suppress fetches and pixels on spacing lines.

Top module: `scc_addr_gen`

## Requirements
- R1: Reset gives address 0x3000, blank low, and the 32-row, 80-byte geometry latched.
- R2: A frame-start strobe latches the geometry and loads the screen start into the address and the line-start. The start is 0x3000 for 32 rows at 80 bytes, 0x4100 for 25 at 80, 0x5800 for 32 at 40, and 0x6000 for 25 at 40. A geometry change between frame starts has no effect.
- R3: When active is high and blank is low, a byte-advance strobe adds 8 to the address.
- R4: Any step result of 0x8000 or above is reduced by 0x8000 minus the latched start.
- R5: When active is high, a line end inside a character row sets the address to the current line-start plus 1 (folded), and that value becomes the new line-start.
- R6: A line end that completes the eighth line of a row sets the address to the current address minus 7, and that value becomes the new line-start.
- R7: In 25-row geometries, each row boundary raises blank for 2 line ends. During those lines a line end only counts the blank line down, and byte advances are ignored.
- R8: In 25-row geometries, the row boundary that completes line 200 raises blank for 64 line ends instead of 2.
- R9: While active is low, line-end and byte-advance strobes change neither the address nor blank.
- R10: Frame start takes priority over a line end or a byte advance in the same cycle. A line end takes priority over a byte advance in the same cycle, and that byte advance is dropped.
- R11: In 32-row geometries, blank never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_short_rows | input | 1 | 1 selects 25 character rows, 0 selects 32 |
| mode_narrow | input | 1 | 1 selects 40 bytes per line, 0 selects 80 |
| frame_start | input | 1 | Single-cycle frame-start strobe |
| line_end | input | 1 | Single-cycle end-of-pixel-line strobe |
| byte_adv | input | 1 | Single-cycle byte-fetch strobe |
| active | input | 1 | High inside the active display region |
| addr_o | output | 15 | Current screen byte address |
| blank_o | output | 1 | High on spacing and footer lines |

## Verification
The footer margin is the hardest state to reach from the ports. It appears only after 200 completed pixel lines in a 25-row geometry, with a 2-line gap after each of the first 24 rows. The stimulus therefore walks a complete frame of byte and line strobes before it counts down the 64 footer lines. The fold is hard to reach as well, because a well-formed frame hits 0x8000 only on its final byte. To reach it, the stimulus also issues far more byte advances than a line holds, with no line end between them. A behavioural model kept in plain integers is compared against the outputs on every clock, including during a pseudo-random mix of overlapping strobes.

// File: rtl/scc_pkg.sv
package scc_pkg;

  typedef struct packed {
    logic short_rows;
    logic narrow;
  } scc_mode_t;

  function automatic int scc_start(int rows, int bpl, int lpr, int limit, int align);
    int size;
    size = bpl * lpr * rows;
    return ((limit - size) / align) * align;
  endfunction

  function automatic int scc_spacing(int rows, int screen_lines, int lpr);
    return screen_lines / rows - lpr;
  endfunction

  function automatic int scc_margin(int rows, int frame_lines, int lpr, int sp);
    return frame_lines - rows * (lpr + sp) + sp;
  endfunction

endpackage

// File: rtl/scc_geom.sv
module scc_geom #(
  parameter int ADDR_W        = 15,
  parameter int LINES_PER_ROW = 8,
  parameter int BYTES_WIDE    = 80,
  parameter int BYTES_NARROW  = 40,
  parameter int ROWS_TALL     = 32,
  parameter int ROWS_SHORT    = 25,
  parameter int SCREEN_LINES  = 256,
  parameter int FRAME_LINES   = 312,
  parameter int START_ALIGN   = 256,
  parameter int SW            = 9,
  parameter int LW            = 10
) (
  input  scc_pkg::scc_mode_t mode,
  output logic [ADDR_W:0]    start,
  output logic [ADDR_W:0]    span,
  output logic [SW-1:0]      spacing,
  output logic [SW-1:0]      margin,
  output logic [LW-1:0]      footer
);
  localparam int AI    = ADDR_W + 1;
  localparam int LIMIT = 1 << ADDR_W;

  logic [AI-1:0] start_t [4];
  logic [AI-1:0] span_t  [4];
  logic [SW-1:0] sp_t    [4];
  logic [SW-1:0] mg_t    [4];
  logic [LW-1:0] ft_t    [4];
  logic [1:0]    idx;

  for (genvar m = 0; m < 4; m++) begin : g_mode
    localparam int R  = ((m / 2) != 0) ? ROWS_SHORT : ROWS_TALL;
    localparam int B  = ((m % 2) != 0) ? BYTES_NARROW : BYTES_WIDE;
    localparam int ST = scc_pkg::scc_start(R, B, LINES_PER_ROW, LIMIT, START_ALIGN);
    localparam int SP = scc_pkg::scc_spacing(R, SCREEN_LINES, LINES_PER_ROW);
    localparam int MG = scc_pkg::scc_margin(R, FRAME_LINES, LINES_PER_ROW, SP);
    assign start_t[m] = AI'(ST);
    assign span_t[m]  = AI'(LIMIT - ST);
    assign sp_t[m]    = SW'(SP);
    assign mg_t[m]    = SW'(MG);
    assign ft_t[m]    = LW'(R * LINES_PER_ROW);
  end

  assign idx     = {mode.short_rows, mode.narrow};
  assign start   = start_t[idx];
  assign span    = span_t[idx];
  assign spacing = sp_t[idx];
  assign margin  = mg_t[idx];
  assign footer  = ft_t[idx];

endmodule

// File: rtl/scc_wrap.sv
module scc_wrap #(
  parameter int AI = 16
) (
  input  logic [AI-1:0] raw,
  input  logic [AI-1:0] span,
  output logic [AI-2:0] fold
);
  localparam logic [AI-1:0] LIM = {1'b1, {(AI-1){1'b0}}};

  logic [AI-1:0] res;

  always_comb begin
    res = raw;
    if (raw >= LIM) res = raw - span;
    fold = res[AI-2:0];
  end

endmodule

// File: rtl/scc_line_seq.sv
module scc_line_seq #(
  parameter int LINES_PER_ROW = 8,
  parameter int SW            = 9,
  parameter int LW            = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          line_go,
  input  logic [SW-1:0] spacing,
  input  logic [SW-1:0] margin,
  input  logic [LW-1:0] footer,
  output logic          blank,
  output logic          adv,
  output logic          row_end
);
  logic [LW-1:0] line_q;
  logic [LW-1:0] line_nx;
  logic [SW-1:0] gap_q;

  assign blank   = (gap_q != '0);
  assign adv     = line_go & ~blank & ~frame_start;
  assign line_nx = line_q + LW'(1);
  assign row_end = ((line_nx % LW'(LINES_PER_ROW)) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      gap_q  <= '0;
    end else if (frame_start) begin
      line_q <= '0;
      gap_q  <= '0;
    end else if (line_go) begin
      if (blank) begin
        gap_q <= gap_q - SW'(1);
      end else begin
        line_q <= line_nx;
        if (row_end) begin
          if ((spacing != '0) && (line_nx == footer)) gap_q <= margin;
          else                                        gap_q <= spacing;
        end
      end
    end
  end

endmodule

// File: rtl/scc_addr_gen.sv
module scc_addr_gen #(
  parameter int ADDR_W        = 15,
  parameter int LINES_PER_ROW = 8,
  parameter int BYTES_WIDE    = 80,
  parameter int BYTES_NARROW  = 40,
  parameter int ROWS_TALL     = 32,
  parameter int ROWS_SHORT    = 25,
  parameter int SCREEN_LINES  = 256,
  parameter int FRAME_LINES   = 312,
  parameter int START_ALIGN   = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_short_rows,
  input  logic              mode_narrow,
  input  logic              frame_start,
  input  logic              line_end,
  input  logic              byte_adv,
  input  logic              active,
  output logic [ADDR_W-1:0] addr_o,
  output logic              blank_o
);
  localparam int AI        = ADDR_W + 1;
  localparam int LIMIT     = 1 << ADDR_W;
  localparam int SW        = $clog2(FRAME_LINES + 1);
  localparam int LW        = $clog2(FRAME_LINES + 1) + 1;
  localparam int RST_START = scc_pkg::scc_start(ROWS_TALL, BYTES_WIDE, LINES_PER_ROW,
                                                LIMIT, START_ALIGN);

  scc_pkg::scc_mode_t mode_in, mode_q;
  logic [ADDR_W-1:0]  addr_q, lstart_q;
  logic [AI-1:0]      new_start, cur_start, cur_span;
  logic [SW-1:0]      spacing, margin;
  logic [SW-1:0]      unused_sp, unused_mg;
  logic [LW-1:0]      footer, unused_ft;
  logic [AI-1:0]      unused_span;
  logic [AI-1:0]      raw  [3];
  logic [ADDR_W-1:0]  fold [3];
  logic               blank, line_adv, row_end, byte_go, line_go;

  assign mode_in = '{short_rows: mode_short_rows, narrow: mode_narrow};

  // Geometry of the incoming selection, used only to load the start.
  scc_geom #(
    .ADDR_W(ADDR_W), .LINES_PER_ROW(LINES_PER_ROW), .BYTES_WIDE(BYTES_WIDE),
    .BYTES_NARROW(BYTES_NARROW), .ROWS_TALL(ROWS_TALL), .ROWS_SHORT(ROWS_SHORT),
    .SCREEN_LINES(SCREEN_LINES), .FRAME_LINES(FRAME_LINES),
    .START_ALIGN(START_ALIGN), .SW(SW), .LW(LW)
  ) u_geom_in (
    .mode(mode_in), .start(new_start), .span(unused_span),
    .spacing(unused_sp), .margin(unused_mg), .footer(unused_ft)
  );

  // Geometry of the latched selection, used for the frame in progress.
  scc_geom #(
    .ADDR_W(ADDR_W), .LINES_PER_ROW(LINES_PER_ROW), .BYTES_WIDE(BYTES_WIDE),
    .BYTES_NARROW(BYTES_NARROW), .ROWS_TALL(ROWS_TALL), .ROWS_SHORT(ROWS_SHORT),
    .SCREEN_LINES(SCREEN_LINES), .FRAME_LINES(FRAME_LINES),
    .START_ALIGN(START_ALIGN), .SW(SW), .LW(LW)
  ) u_geom_cur (
    .mode(mode_q), .start(cur_start), .span(cur_span),
    .spacing(spacing), .margin(margin), .footer(footer)
  );

  // Three step paths: along the line, next line of the cell, back to row top.
  for (genvar k = 0; k < 3; k++) begin : g_step
    localparam int D = (k == 0) ? LINES_PER_ROW : ((k == 1) ? 1 : -(LINES_PER_ROW - 1));
    assign raw[k] = ((k == 1) ? {1'b0, lstart_q} : {1'b0, addr_q}) + AI'(D);
    scc_wrap #(.AI(AI)) u_wrap (.raw(raw[k]), .span(cur_span), .fold(fold[k]));
  end

  assign line_go = active & line_end;

  scc_line_seq #(
    .LINES_PER_ROW(LINES_PER_ROW), .SW(SW), .LW(LW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_go(line_go),
    .spacing(spacing), .margin(margin), .footer(footer),
    .blank(blank), .adv(line_adv), .row_end(row_end)
  );

  assign byte_go = active & byte_adv & ~line_end & ~frame_start & ~blank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      addr_q   <= ADDR_W'(RST_START);
      lstart_q <= ADDR_W'(RST_START);
    end else if (frame_start) begin
      mode_q   <= mode_in;
      addr_q   <= new_start[ADDR_W-1:0];
      lstart_q <= new_start[ADDR_W-1:0];
    end else if (line_adv) begin
      addr_q   <= row_end ? fold[2] : fold[1];
      lstart_q <= row_end ? fold[2] : fold[1];
    end else if (byte_go) begin
      addr_q   <= fold[0];
    end
  end

  assign addr_o  = addr_q;
  assign blank_o = blank;

endmodule

// File: rtl/scc_addr_gen_chk.sv
module scc_addr_gen_chk #(
  parameter int ADDR_W        = 15,
  parameter int LINES_PER_ROW = 8,
  parameter int BYTES_WIDE    = 80,
  parameter int BYTES_NARROW  = 40,
  parameter int ROWS_TALL     = 32,
  parameter int ROWS_SHORT    = 25,
  parameter int START_ALIGN   = 256
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_short_rows,
  input logic               mode_narrow,
  input logic               frame_start,
  input logic               line_end,
  input logic               byte_adv,
  input logic               active,
  input logic [ADDR_W-1:0]  addr_o,
  input logic               blank_o,
  input scc_pkg::scc_mode_t mode_q
);
  localparam int LIMIT = 1 << ADDR_W;

  int cur_start, in_start;

  always_comb begin
    cur_start = scc_pkg::scc_start(mode_q.short_rows ? ROWS_SHORT : ROWS_TALL,
                                   mode_q.narrow ? BYTES_NARROW : BYTES_WIDE,
                                   LINES_PER_ROW, LIMIT, START_ALIGN);
    in_start  = scc_pkg::scc_start(mode_short_rows ? ROWS_SHORT : ROWS_TALL,
                                   mode_narrow ? BYTES_NARROW : BYTES_WIDE,
                                   LINES_PER_ROW, LIMIT, START_ALIGN);
  end

  // R2: frame start loads the start of the sampled geometry
  a_r2_frame_load: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (int'(addr_o) == $past(in_start)) && !blank_o);

  // R3: accepted byte advance steps by 8 unless it folded
  a_r3_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_adv && active && !blank_o && !line_end && !frame_start) |=>
      (int'(addr_o) == int'($past(addr_o)) + LINES_PER_ROW) ||
      (int'($past(addr_o)) + LINES_PER_ROW >= LIMIT));

  // R4: address stays inside the screen region
  a_r4_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    int'(addr_o) >= cur_start);

  // R7: byte advances during blank lines leave the address alone
  a_r7_blank_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_o && !frame_start) |=> $stable(addr_o));

  // R9: strobes outside the active region change nothing
  a_r9_inactive_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !frame_start) |=> $stable(addr_o) && $stable(blank_o));

  // R11: no blank lines with 32 rows
  a_r11_tall_no_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q.short_rows |-> !blank_o);

endmodule

bind scc_addr_gen scc_addr_gen_chk #(
  .ADDR_W(ADDR_W), .LINES_PER_ROW(LINES_PER_ROW), .BYTES_WIDE(BYTES_WIDE),
  .BYTES_NARROW(BYTES_NARROW), .ROWS_TALL(ROWS_TALL), .ROWS_SHORT(ROWS_SHORT),
  .START_ALIGN(START_ALIGN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_short_rows(mode_short_rows),
  .mode_narrow(mode_narrow), .frame_start(frame_start), .line_end(line_end),
  .byte_adv(byte_adv), .active(active), .addr_o(addr_o), .blank_o(blank_o),
  .mode_q(mode_q)
);

// File: tb/tb_scc_addr_gen.sv
module tb_scc_addr_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_short = 1'b0, m_narrow = 1'b0;
  logic fs = 1'b0, le = 1'b0, ba = 1'b0, act = 1'b0;
  logic [14:0] addr;
  logic blank;

  int nchk = 0, nerr = 0;
  bit running = 1'b0, done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int m_rows = 32, m_bpl = 80, m_addr = 'h3000, m_ls = 'h3000, m_line = 0, m_gap = 0;

  always #4 clk = ~clk;

  scc_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .mode_short_rows(m_short), .mode_narrow(m_narrow),
    .frame_start(fs), .line_end(le), .byte_adv(ba), .active(act),
    .addr_o(addr), .blank_o(blank)
  );

  function automatic int start_of(int rows, int bpl);
    return ((32768 - bpl * 8 * rows) / 256) * 256;
  endfunction

  function automatic int fold(int a);
    if (a >= 32768) return a - (32768 - start_of(m_rows, m_bpl));
    return a;
  endfunction

  always @(posedge clk) begin
    int sp;
    if (!rst_n) begin
      m_rows = 32; m_bpl = 80; m_addr = 'h3000; m_ls = 'h3000; m_line = 0; m_gap = 0;
    end else if (fs) begin
      m_rows = m_short ? 25 : 32;
      m_bpl  = m_narrow ? 40 : 80;
      m_addr = start_of(m_rows, m_bpl); m_ls = m_addr; m_line = 0; m_gap = 0;
    end else if (act && le) begin
      if (m_gap > 0) m_gap--;
      else begin
        m_line++;
        sp = 256 / m_rows - 8;
        if (m_line % 8 != 0) m_addr = fold(m_ls + 1);
        else begin
          m_addr = fold(m_addr - 7);
          if (sp != 0 && m_line == m_rows * 8) m_gap = 312 - m_rows * (8 + sp) + sp;
          else m_gap = sp;
        end
        m_ls = m_addr;
      end
    end else if (act && ba && m_gap == 0) begin
      m_addr = fold(m_addr + 8);
    end
  end

  always @(negedge clk) begin
    if (running) begin
      nchk++;
      if (int'(addr) != m_addr || blank != (m_gap != 0)) begin
        nerr++;
        $display("FAIL %s per-clock addr %0h blank %0b exp addr %0h blank %0b",
                 cur_req, addr, blank, m_addr, m_gap != 0);
      end
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic pulse(input bit f, input bit l, input bit b);
    @(negedge clk);
    fs = f; le = l; ba = b;
    @(posedge clk);
    #1;
    fs = 1'b0; le = 1'b0; ba = 1'b0;
  endtask

  task automatic do_line(input int nbytes);
    for (int i = 0; i < nbytes; i++) pulse(1'b0, 1'b0, 1'b1);
    pulse(1'b0, 1'b1, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      running = 1'b0;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    running = 1'b1;
    chk("R1 reset addr", int'(addr), 'h3000);
    chk("R1 reset blank", int'(blank), 0);

    // 32 rows, 80 bytes; inputs then switch to 25 rows without a frame start
    cur_req = "R2";
    pulse(1'b1, 1'b0, 1'b0);
    chk("R2 start 32x80", int'(addr), 'h3000);
    m_short = 1'b1;
    act = 1'b1;
    cur_req = "R3";
    for (int i = 0; i < 80; i++) pulse(1'b0, 1'b0, 1'b1);
    chk("R3 byte steps", int'(addr), 'h3280);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R5 next line", int'(addr), 'h3001);
    for (int l = 1; l < 8; l++) do_line(80);
    chk("R6 row boundary", int'(addr), 'h3280);
    chk("R11 no blank after row", int'(blank), 0);
    cur_req = "R11";
    for (int l = 8; l < 256; l++) do_line(80);
    chk("R4 fold at frame end", int'(addr), 'h3000);
    chk("R2 mode change ignored mid-frame", int'(blank), 0);

    // inactive strobes
    cur_req = "R9";
    act = 1'b0;
    pulse(1'b0, 1'b1, 1'b1);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R9 inactive hold", int'(addr), 'h3000);

    // priorities, then a full 25-row frame at 80 bytes
    cur_req = "R10";
    act = 1'b1; m_short = 1'b1; m_narrow = 1'b0;
    pulse(1'b1, 1'b1, 1'b1);
    chk("R10 frame start wins", int'(addr), 'h4100);
    pulse(1'b0, 1'b1, 1'b1);
    chk("R10 line end beats byte", int'(addr), 'h4101);
    pulse(1'b1, 1'b0, 1'b0);
    cur_req = "R7";
    for (int l = 0; l < 8; l++) do_line(80);
    chk("R7 gap after row", int'(blank), 1);
    chk("R7 row boundary addr", int'(addr), 'h4380);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R7 byte ignored in gap", int'(addr), 'h4380);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R7 still blank", int'(blank), 1);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R7 gap ends", int'(blank), 0);
    cur_req = "R8";
    for (int r = 1; r < 25; r++) begin
      for (int l = 0; l < 8; l++) do_line(80);
      if (r < 24) begin
        pulse(1'b0, 1'b1, 1'b0);
        pulse(1'b0, 1'b1, 1'b0);
      end
    end
    chk("R8 footer blank", int'(blank), 1);
    chk("R8 footer addr", int'(addr), 'h7F80);
    for (int i = 0; i < 63; i++) pulse(1'b0, 1'b1, 1'b0);
    chk("R8 footer still blank", int'(blank), 1);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R8 footer ends", int'(blank), 0);

    // 32 rows, 40 bytes; fold by overrunning a line
    cur_req = "R4";
    m_short = 1'b0; m_narrow = 1'b1;
    pulse(1'b1, 1'b0, 1'b0);
    chk("R2 start 32x40", int'(addr), 'h5800);
    for (int i = 0; i < 1280; i++) pulse(1'b0, 1'b0, 1'b1);
    chk("R4 fold to start", int'(addr), 'h5800);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R4 after fold", int'(addr), 'h5808);

    m_short = 1'b1;
    pulse(1'b1, 1'b0, 1'b0);
    chk("R2 start 25x40", int'(addr), 'h6000);

    // pseudo-random mix of overlapping strobes
    cur_req = "R10";
    lfsr = 'h1ACE;
    for (int i = 0; i < 4000; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 'hB400 : 0);
      act = (lfsr[3:0] != 4'h0);
      m_short = lfsr[5]; m_narrow = lfsr[6];
      pulse(lfsr[15:9] == 7'h00, lfsr[8:7] == 2'b11, lfsr[10] | lfsr[11]);
    end

    @(negedge clk);
    finish_run();
  end

endmodule